// File: doc/BRIEF.md
# Spread-FSK Direct Digital Synthesis Transmitter

This block produces the digital sine samples of a spread frequency-shift-keyed power-line transmitter. Two carriers far apart in frequency are used: a logic 0 is sent on the space carrier and a logic 1 on the mark carrier. Each carrier is set in units of 10 Hz. The block turns each setting into a 32-bit phase increment with a constant multiply. A phase accumulator then steps by the increment that the current bit selects. A 256-entry quarter-wave table of 12-bit magnitudes, folded by the top two phase bits, turns the phase into a signed sample.

Next to the samples, the block drives the plain data level of the tone now on air. It also drives a transmit enable that stays high for a programmed number of clocks after the frame ends, to cover the delay of the analog path. The controller is a three-state machine. **IDLE** takes a new pair of settings on a frame request (transition *start*) when the pair is legal. An illegal pair raises an error flag and keeps the block in IDLE (transition *reject*). **RUN** synthesises tones and takes a new bit on each bit strobe. When the request drops it goes to **HOLD** (transition *release*). **HOLD** keeps the enable high with the output silent, and returns to IDLE when its counter expires (transition *expire*).

Top module: `sfsk_dds_tx`

## Requirements
- R1: After reset, tx_en, data_lvl and cfg_err are 0 and sample is 0.
- R2: A frame request in IDLE is accepted only if both settings lie in 900..9500 (units of 10 Hz) and the two settings differ by more than 1000. An accepted request raises tx_en at the next clock and clears cfg_err. A rejected request sets cfg_err to 1 and leaves tx_en at 0. cfg_err keeps its value until the next request.
- R3: While running, bit 0 produces a tone of space_set x 10 Hz and bit 1 produces a tone of mark_set x 10 Hz, with a 12 MHz clock.
- R4: data_lvl is 1 when the mark carrier is selected and 0 when the space carrier is selected. The bit changes only on a clock with bit_stb high; bit_val without bit_stb has no effect on data_lvl or on the tone.
- R5: A change of carrier keeps the accumulated phase, so consecutive samples never differ by more than the step of the faster carrier (bench bound 300 LSB).
- R6: Settings are captured only when a frame starts. Changes on space_set or mark_set during a frame do not change the tone.
- R7: After frame_req is sampled low in RUN, tx_en stays high for exactly HOLD_CYC clocks (default 4500, i.e. 0.375 ms) and then falls.
- R8: Whenever the block is not in RUN, sample is 0 and data_lvl is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz synthesis clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_req | input | 1 | High for the whole frame |
| bit_stb | input | 1 | One-clock strobe that takes bit_val |
| bit_val | input | 1 | Data bit: 0 space, 1 mark |
| space_set | input | 14 | Space carrier in 10 Hz units |
| mark_set | input | 14 | Mark carrier in 10 Hz units |
| sample | output | 13 | Signed sine sample, range +/-4095 |
| data_lvl | output | 1 | Plain level of the tone being sent |
| tx_en | output | 1 | Transmit enable, including the turn-off delay |
| cfg_err | output | 1 | Last frame request had an illegal setting pair |

## Verification
- **Accept or reject (R2):** the state and the error flag change at the clock edge that samples the request, so tx_en and cfg_err are checked at the falling edge that follows.
- **Data level (R4):** data_lvl is checked one falling edge after the bit strobe.
- **Turn-off delay (R7):** once frame_req is dropped, tx_en is counted at every falling edge, and the count must equal HOLD_CYC exactly.
- **Tone frequency (R3, R6):** samples lag the accumulator by one register, so frequency is judged over a 12000-clock window by counting rising zero crossings. This makes the check independent of the pipeline offset.
- **Phase continuity (R5):** the largest step between consecutive samples is tracked while bits toggle.

// File: rtl/sfsk_pkg.sv
package sfsk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tx_state_e;

    // Rational sine approximation over one quarter, sampled mid-bin.
    function automatic longint quarter_sine(input longint idx, input int addr_w, input longint amp);
        longint half_p;
        longint u;
        longint prod;
        longint num;
        longint den;
        half_p = longint'(1) << (addr_w + 2);
        u      = 2 * idx + 1;
        prod   = u * (half_p - u);
        num    = 4 * prod;
        den    = (5 * half_p * half_p) / 4 - prod;
        return (amp * num + den / 2) / den;
    endfunction

    // Fixed-point constant: phase increment per setting step, scaled by 2^frac.
    function automatic longint step_const(input longint clk_hz, input longint step_hz,
                                          input int acc_w, input int frac);
        return ((longint'(1) << (acc_w + frac)) * step_hz + clk_hz / 2) / clk_hz;
    endfunction

endpackage

// File: rtl/sfsk_cfg_check.sv
module sfsk_cfg_check #(
    parameter int     SET_W   = 14,
    parameter int     ACC_W   = 32,
    parameter int     FRAC_W  = 8,
    parameter longint CLK_HZ  = 12000000,
    parameter longint STEP_HZ = 10,
    parameter int     MIN_SET = 900,
    parameter int     MAX_SET = 9500,
    parameter int     MIN_GAP = 1000
) (
    input  logic [SET_W-1:0] space_set,
    input  logic [SET_W-1:0] mark_set,
    output logic             pair_ok,
    output logic [ACC_W-1:0] tw_space,
    output logic [ACC_W-1:0] tw_mark
);
    localparam longint TW_K = sfsk_pkg::step_const(CLK_HZ, STEP_HZ, ACC_W, FRAC_W);
    localparam logic [63:0] TW_K64 = 64'(TW_K);

    logic       space_in, mark_in, gap_ok;
    logic [SET_W-1:0] gap;

    always_comb begin
        space_in = (int'(space_set) >= MIN_SET) && (int'(space_set) <= MAX_SET);
        mark_in  = (int'(mark_set)  >= MIN_SET) && (int'(mark_set)  <= MAX_SET);
        gap      = (space_set > mark_set) ? (space_set - mark_set) : (mark_set - space_set);
        gap_ok   = int'(gap) > MIN_GAP;
        pair_ok  = space_in && mark_in && gap_ok;
        tw_space = ACC_W'((64'(space_set) * TW_K64) >> FRAC_W);
        tw_mark  = ACC_W'((64'(mark_set)  * TW_K64) >> FRAC_W);
    end
endmodule

// File: rtl/sfsk_phase_acc.sv
module sfsk_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    output logic [ACC_W-1:0] phase
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (en) begin
            phase <= phase + inc;
        end
    end
endmodule

// File: rtl/sfsk_sine_lut.sv
module sfsk_sine_lut #(
    parameter int AW = 8,
    parameter int DW = 12
) (
    input  logic [AW+1:0]        ph,
    output logic signed [DW:0]   val
);
    localparam int DEPTH = 1 << AW;
    localparam longint AMP = (longint'(1) << DW) - 1;

    logic [DW-1:0] rom [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
        assign rom[gi] = DW'(sfsk_pkg::quarter_sine(longint'(gi), AW, AMP));
    end

    logic [AW-1:0]   idx;
    logic [DW-1:0]   mag;
    logic signed [DW:0] pos;

    always_comb begin
        idx = ph[AW] ? ~ph[AW-1:0] : ph[AW-1:0];
        mag = rom[idx];
        pos = $signed({1'b0, mag});
        val = ph[AW+1] ? -pos : pos;
    end
endmodule

// File: rtl/sfsk_dds_tx.sv
module sfsk_dds_tx #(
    parameter int     SET_W    = 14,
    parameter int     ACC_W    = 32,
    parameter int     LUT_AW   = 8,
    parameter int     AMP_W    = 12,
    parameter longint CLK_HZ   = 12000000,
    parameter int     HOLD_CYC = 4500
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_req,
    input  logic                    bit_stb,
    input  logic                    bit_val,
    input  logic [SET_W-1:0]        space_set,
    input  logic [SET_W-1:0]        mark_set,
    output logic signed [AMP_W:0]   sample,
    output logic                    data_lvl,
    output logic                    tx_en,
    output logic                    cfg_err
);
    import sfsk_pkg::*;

    localparam int HC_W = $clog2(HOLD_CYC + 1);
    localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_CYC - 1);

    tx_state_e st, st_nx;

    logic             pair_ok;
    logic [ACC_W-1:0] tw_space_c, tw_mark_c;
    logic [ACC_W-1:0] tw_space_q, tw_mark_q;
    logic [ACC_W-1:0] phase;
    logic             bit_q;
    logic [HC_W-1:0]  hold_cnt;
    logic signed [AMP_W:0] lut_val, sample_q;
    logic             run_st, hold_st, start;

    sfsk_cfg_check #(
        .SET_W (SET_W),
        .ACC_W (ACC_W),
        .CLK_HZ(CLK_HZ)
    ) u_cfg (
        .space_set(space_set),
        .mark_set (mark_set),
        .pair_ok  (pair_ok),
        .tw_space (tw_space_c),
        .tw_mark  (tw_mark_c)
    );

    assign run_st  = (st == ST_RUN);
    assign hold_st = (st == ST_HOLD);
    assign start   = (st == ST_IDLE) && frame_req && pair_ok;

    sfsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (run_st),
        .inc  (bit_q ? tw_mark_q : tw_space_q),
        .phase(phase)
    );

    sfsk_sine_lut #(.AW(LUT_AW), .DW(AMP_W)) u_lut (
        .ph (phase[ACC_W-1 -: LUT_AW+2]),
        .val(lut_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Transitions: start / reject / release / expire
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start)                st_nx = ST_RUN;
            ST_RUN:  if (!frame_req)           st_nx = ST_HOLD;
            ST_HOLD: if (hold_cnt == '0)       st_nx = ST_IDLE;
            default:                           st_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_space_q <= '0;
            tw_mark_q  <= '0;
            bit_q      <= 1'b0;
            hold_cnt   <= '0;
            cfg_err    <= 1'b0;
            sample_q   <= '0;
        end else begin
            if (st == ST_IDLE && frame_req) begin
                cfg_err <= !pair_ok;
            end
            if (start) begin
                tw_space_q <= tw_space_c;
                tw_mark_q  <= tw_mark_c;
                bit_q      <= 1'b0;
            end else if (run_st && bit_stb) begin
                bit_q <= bit_val;
            end
            if (run_st && !frame_req) begin
                hold_cnt <= HOLD_LAST;
            end else if (hold_st && hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
            sample_q <= run_st ? lut_val : '0;
        end
    end

    // Outputs
    always_comb begin
        tx_en    = (st != ST_IDLE);
        sample   = run_st ? sample_q : '0;
        data_lvl = run_st & bit_q;
    end
endmodule

// File: rtl/sfsk_dds_tx_chk.sv
module sfsk_dds_tx_chk #(
    parameter int ACC_W    = 32,
    parameter int AMP_W    = 12,
    parameter int HOLD_CYC = 4500
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tx_en,
    input logic signed [AMP_W:0] sample,
    input logic                  data_lvl,
    input logic                  cfg_err,
    input logic                  bit_stb,
    input logic                  run_st,
    input logic                  hold_st,
    input logic [ACC_W-1:0]      tw_space_q,
    input logic [ACC_W-1:0]      tw_mark_q
);
    localparam int CW = $clog2(HOLD_CYC + 2);
    logic [CW-1:0] hold_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_seen <= '0;
        else if (hold_st) hold_seen <= hold_seen + 1'b1;
        else              hold_seen <= '0;
    end

    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (sample == '0 && !data_lvl));

    assert_err_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !tx_en);

    assert_lvl_needs_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && !bit_stb) |=> (run_st -> $stable(data_lvl)));

    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_st |=> (run_st -> ($stable(tw_space_q) && $stable(tw_mark_q))));

    assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hold_seen) <= HOLD_CYC);

    assert_hold_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_st |-> tx_en);
endmodule

bind sfsk_dds_tx sfsk_dds_tx_chk #(
    .ACC_W   (ACC_W),
    .AMP_W   (AMP_W),
    .HOLD_CYC(HOLD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .sample    (sample),
    .data_lvl  (data_lvl),
    .cfg_err   (cfg_err),
    .bit_stb   (bit_stb),
    .run_st    (run_st),
    .hold_st   (hold_st),
    .tw_space_q(tw_space_q),
    .tw_mark_q (tw_mark_q)
);

// File: tb/sfsk_dds_tx_bench.sv
module sfsk_dds_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4500;
    localparam int WIN        = 12000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_req = 1'b0;
    logic               bit_stb = 1'b0;
    logic               bit_val = 1'b0;
    logic [13:0]        space_set = '0;
    logic [13:0]        mark_set = '0;
    logic signed [12:0] sample;
    logic               data_lvl, tx_en, cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfsk_dds_tx #(.HOLD_CYC(HOLD)) u_sfsk_dds_tx (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .bit_stb(bit_stb),
        .bit_val(bit_val), .space_set(space_set), .mark_set(mark_set),
        .sample(sample), .data_lvl(data_lvl), .tx_en(tx_en), .cfg_err(cfg_err)
    );

    // {space, mark, expect_reject}
    localparam logic [28:0] VEC [8] = '{
        {14'd9500, 14'd900,  1'b0},
        {14'd899,  14'd5000, 1'b1},
        {14'd5000, 14'd9501, 1'b1},
        {14'd3000, 14'd4000, 1'b1},
        {14'd3000, 14'd4001, 1'b0},
        {14'd9500, 14'd9500, 1'b1},
        {14'd4001, 14'd3000, 1'b0},
        {14'd900,  14'd9500, 1'b0}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < HOLD + 10 && tx_en; i++) @(negedge clk);
    endtask

    task automatic strobe(input logic b);
        bit_val = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic count_cross(output int nc);
        logic signed [12:0] prev;
        nc = 0;
        prev = sample;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (prev < 0 && sample >= 0) nc++;
            prev = sample;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nc, exp_nc, maxd, d, cnt;
        logic signed [12:0] prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_en == 1'b0, "R1 tx_en", int'(tx_en), 0);
        check(data_lvl == 1'b0, "R1 data_lvl", int'(data_lvl), 0);
        check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
        check(sample == 0, "R1 sample", int'(sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 table walk
        for (int v = 0; v < 8; v++) begin
            space_set = VEC[v][28:15];
            mark_set  = VEC[v][14:1];
            frame_req = 1'b1;
            @(negedge clk);
            frame_req = 1'b0;
            check(cfg_err == VEC[v][0], "R2 cfg_err", int'(cfg_err), int'(VEC[v][0]));
            check(tx_en == !VEC[v][0], "R2 tx_en", int'(tx_en), int'(!VEC[v][0]));
            @(negedge clk);
            wait_idle();
            // R8 idle output silent
            check(sample == 0 && !data_lvl, "R8 idle", int'(sample), 0);
        end

        // R3 space tone
        space_set = 14'd9500;
        mark_set  = 14'd900;
        frame_req = 1'b1;
        @(negedge clk);
        strobe(1'b0);
        check(data_lvl == 1'b0, "R4 space level", int'(data_lvl), 0);
        count_cross(nc);
        exp_nc = 9500 / 100;
        check(nc >= exp_nc - 1 && nc <= exp_nc + 1, "R3 space freq", nc, exp_nc);

        // R3 mark tone and R4 level
        strobe(1'b1);
        check(data_lvl == 1'b1, "R4 mark level", int'(data_lvl), 1);
        bit_val = 1'b0;
        count_cross(nc);
        exp_nc = 900 / 100;
        check(nc >= exp_nc - 1 && nc <= exp_nc + 1, "R3 mark freq", nc, exp_nc);
        // R4 bit_val without strobe ignored
        check(data_lvl == 1'b1, "R4 no strobe", int'(data_lvl), 1);

        // R6 mid-frame setting change ignored
        space_set = 14'd2000;
        mark_set  = 14'd5000;
        strobe(1'b0);
        count_cross(nc);
        check(nc >= 94 && nc <= 96, "R6 settings frozen", nc, 95);

        // R5 phase continuity while toggling
        maxd = 0;
        prev = sample;
        for (int i = 0; i < 3000; i++) begin
            if (i % 37 == 0) begin
                bit_val = ~bit_val;
                bit_stb = 1'b1;
            end else begin
                bit_stb = 1'b0;
            end
            @(negedge clk);
            d = int'(sample) - int'(prev);
            if (d < 0) d = -d;
            if (d > maxd) maxd = d;
            prev = sample;
        end
        bit_stb = 1'b0;
        check(maxd <= 300, "R5 max step", maxd, 300);

        // R7 turn-off delay, R8 silent during hold
        frame_req = 1'b0;
        @(negedge clk);
        cnt = 0;
        maxd = 0;
        for (int i = 0; i < HOLD + 20 && tx_en; i++) begin
            cnt++;
            if (sample != 0 || data_lvl) maxd++;
            @(negedge clk);
        end
        check(cnt == HOLD, "R7 hold length", cnt, HOLD);
        check(maxd == 0, "R8 hold silent", maxd, 0);
        check(tx_en == 1'b0, "R7 enable off", int'(tx_en), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule